// File: doc/BRIEF.md
# Non-Volatile Commit and Power-Up Sequencer

This block sits behind a two-wire serial slave front end and owns the persistent register array of a digitally controlled potentiometer. The front end decodes the bus and hands the block short event pulses: the last bit of a received write data byte (with its target index and value), the acknowledge slot that follows it, START, STOP, and any other bus bit. The block decides whether a write goes straight to the volatile wiper code or is held as a pending persistent write. A pending write runs a programming cycle of fixed length only when a STOP follows its acknowledge with nothing in between.

While a programming cycle runs, the block drops `dev_ready`. The front end uses this signal to stay silent, so a master that polls with address bytes gets no acknowledge until the cycle ends. The block also sequences power-up. The wiper code starts at midscale and is loaded from the stored initial value once the supply-good input asserts. The storage array survives a logic reset and is cleared back to its defaults only by the power reset.

Top module: `nv_commit_seq`

## Requirements
- R1: During and after either reset, and until the supply-good input is sampled high, `wiper_code` is 80h and `dev_ready` is 0.
- R2: On the first clock with `supply_ok` high after reset, `wiper_code` takes the value of storage index 0 and `dev_ready` becomes 1.
- R3: A write strobe with `wr_vol`=1 that is accepted sets `wiper_code` to `wr_data` on the next clock, and it never changes the storage array. Write protect does not refuse it.
- R4: A persistent write to storage index 0 (`wr_vol`=0, `wr_addr`=0) moves `wiper_code` to `wr_data` on the next clock, before any programming. A persistent write to any other index leaves `wiper_code` unchanged.
- R5: A pending persistent write that sees `ack_pulse` and then `stop_pulse`, with no other event between them, raises `busy` on the clock that samples the STOP. `busy` stays high for exactly PROG_CYCLES clocks, and the storage entry holds the new value once `busy` falls.
- R6: A pending persistent write is discarded, with no `busy` and no change to storage, if `bit_pulse`, `start_pulse` or a further write strobe arrives after its strobe, or if STOP arrives before its acknowledge.
- R7: With `wp_n` low, a persistent write strobe is refused (`wr_nack`=1 on the next clock). If `wp_n` goes low while a write is pending, the write is discarded. If `wp_n` goes low during `busy`, the cycle completes and storage is updated.
- R8: While `busy` is high, `dev_ready` is 0. Any write strobe is refused with `wr_nack` and has no effect on `wiper_code` or storage.
- R9: Once a persistent write has been latched, every further write strobe is refused until a STOP. After that STOP, writes are accepted again.
- R10: Storage contents survive `rst_n`. `por_n` low sets index 0 to 80h and all other indices to 00h. `rd_data` shows the entry at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Logic reset, active low; storage is kept |
| por_n | input | 1 | Power reset, active low; storage returns to defaults |
| supply_ok | input | 1 | Supply good enough to read storage |
| wp_n | input | 1 | Write protect, active low |
| wr_strobe | input | 1 | Last bit of a write data byte received |
| wr_vol | input | 1 | 1: the byte targets the volatile wiper only |
| wr_addr | input | ADDR_W | Storage index of a persistent write |
| wr_data | input | 8 | Data byte of the write |
| ack_pulse | input | 1 | Acknowledge slot of the data byte completed |
| start_pulse | input | 1 | START or repeated START seen |
| stop_pulse | input | 1 | STOP seen |
| bit_pulse | input | 1 | Any other bus bit clocked |
| rd_addr | input | ADDR_W | Storage index to read |
| rd_data | output | 8 | Storage entry at rd_addr (00h if out of range) |
| wiper_code | output | 8 | Active tap code; 00h is the low end, FFh the high end |
| busy | output | 1 | Programming cycle in progress |
| dev_ready | output | 1 | Front end may acknowledge its address |
| wr_nack | output | 1 | Last write strobe was refused |

## Verification
The bench targets the commit window. It places a stray bus bit, a repeated START, or an early STOP around the acknowledge, and checks that nothing is programmed. A design that armed on any STOP would write corrupted or aborted transfers into storage. It also drops write protect at three points: before the strobe, while the write is pending, and during the cycle. A design that sampled protect at the wrong time would either program protected data or abort a cycle that had already started. Finally, it counts the exact length of `busy` and checks that storage survives a logic reset while power reset restores the defaults.

// File: rtl/nv_commit_seq.sv
module nv_commit_seq #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NV_DEPTH    = 7,
  parameter int PROG_CYCLES = 40,
  parameter logic [DATA_W-1:0] MIDSCALE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              supply_ok,
  input  logic              wp_n,
  input  logic              wr_strobe,
  input  logic              wr_vol,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_pulse,
  input  logic              start_pulse,
  input  logic              stop_pulse,
  input  logic              bit_pulse,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wiper_code,
  output logic              busy,
  output logic              dev_ready,
  output logic              wr_nack
);
  localparam int CNT_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  logic [DATA_W-1:0] mem [NV_DEPTH];
  logic [ADDR_W-1:0] pend_idx;
  logic [DATA_W-1:0] pend_dat;
  logic [CNT_W-1:0]  cnt;
  logic pend, armed, locked, pu_done;
  logic rst_all_n;

  assign rst_all_n = rst_n & por_n;
  assign dev_ready = pu_done & ~busy;

  logic accept, idx_ok, other_ev, take_vol, take_nv, refuse, cancel, commit, prog_end;
  assign accept   = dev_ready & ~locked;
  assign idx_ok   = (32'(wr_addr) < NV_DEPTH);
  assign other_ev = start_pulse | bit_pulse | wr_strobe;
  assign take_vol = wr_strobe & accept & wr_vol;
  assign take_nv  = wr_strobe & accept & ~wr_vol & wp_n & idx_ok;
  assign refuse   = wr_strobe & ~take_vol & ~take_nv;
  assign commit   = pend & armed & stop_pulse & wp_n & ~other_ev;
  assign cancel   = pend & (other_ev | ~wp_n | stop_pulse);
  assign prog_end = busy & (cnt == '0);

  assign rd_data = (32'(rd_addr) < NV_DEPTH) ? mem[rd_addr[$clog2(NV_DEPTH)-1:0]] : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NV_DEPTH; i++) mem[i] <= (i == 0) ? MIDSCALE : '0;
    end else if (prog_end) begin
      mem[pend_idx[$clog2(NV_DEPTH)-1:0]] <= pend_dat;
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      wiper_code <= MIDSCALE;
      pu_done    <= 1'b0;
    end else if (take_vol || (take_nv && wr_addr == '0)) begin
      wiper_code <= wr_data;
    end else if (!pu_done && supply_ok) begin
      wiper_code <= mem[0];
      pu_done    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      pend     <= 1'b0;
      armed    <= 1'b0;
      locked   <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      wr_nack  <= 1'b0;
      pend_idx <= '0;
      pend_dat <= '0;
    end else begin
      wr_nack <= refuse;
      if (take_nv)         locked <= 1'b1;
      else if (stop_pulse) locked <= 1'b0;
      if (commit) begin
        pend  <= 1'b0;
        armed <= 1'b0;
        busy  <= 1'b1;
        cnt   <= CNT_LAST;
      end else if (cancel) begin
        pend  <= 1'b0;
        armed <= 1'b0;
      end else if (take_nv) begin
        pend     <= 1'b1;
        armed    <= 1'b0;
        pend_idx <= wr_addr;
        pend_dat <= wr_data;
      end else if (pend && ack_pulse) begin
        armed <= 1'b1;
      end
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // R1
  mid_before_recall_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    !pu_done |-> wiper_code == MIDSCALE);
  // R5
  stop_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(busy) |-> $past(stop_pulse) && $past(wp_n));
  // R8
  quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    busy |-> !dev_ready);
  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    busy && wr_strobe |=> wr_nack && $stable(wiper_code));
  // R3
  vol_move_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    wr_strobe && wr_vol && dev_ready && !locked |=> wiper_code == $past(wr_data));
  // R9
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_all_n)
    pend && wr_strobe |=> wr_nack);
endmodule

// File: tb/nv_commit_seq_bench.sv
module nv_commit_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 40;

  logic clk = 0, rst_n = 0, por_n = 0, supply_ok = 0, wp_n = 1;
  logic wr_strobe = 0, wr_vol = 0, ack_pulse = 0, start_pulse = 0, stop_pulse = 0, bit_pulse = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, wiper_code;
  logic busy, dev_ready, wr_nack;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_commit_seq #(.PROG_CYCLES(PROG)) u_nv_commit_seq (
    .clk, .rst_n, .por_n, .supply_ok, .wp_n, .wr_strobe, .wr_vol, .wr_addr, .wr_data,
    .ack_pulse, .start_pulse, .stop_pulse, .bit_pulse, .rd_addr, .rd_data,
    .wiper_code, .busy, .dev_ready, .wr_nack);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic vol, logic [3:0] a, logic [7:0] d);
    wr_vol = vol; wr_addr = a; wr_data = d; wr_strobe = 1;
    @(negedge clk); wr_strobe = 0;
  endtask
  task automatic ack();   ack_pulse = 1;   @(negedge clk); ack_pulse = 0;   endtask
  task automatic stop();  stop_pulse = 1;  @(negedge clk); stop_pulse = 0;  endtask
  task automatic start(); start_pulse = 1; @(negedge clk); start_pulse = 0; endtask
  task automatic bbit();  bit_pulse = 1;   @(negedge clk); bit_pulse = 0;   endtask

  task automatic peek(string req, logic [3:0] a, logic [7:0] exp);
    rd_addr = a; #1; check(req, rd_data, exp);
  endtask

  task automatic count_busy(string req, int exp);
    int n = 0;
    while (busy && n < 10 * PROG) begin n++; @(negedge clk); end
    check(req, n, exp);
  endtask

  task automatic t_powerup();
    @(negedge clk); @(negedge clk);
    rst_n = 1; por_n = 1;
    repeat (3) @(negedge clk);
    check("R1 wiper midscale", wiper_code, 8'h80);
    check("R1 not ready", dev_ready, 0);
    peek("R10 default idx0", 0, 8'h80);
    peek("R10 default idx3", 3, 8'h00);
    supply_ok = 1; @(negedge clk);
    check("R2 recall", wiper_code, 8'h80);
    check("R2 ready", dev_ready, 1);
  endtask

  task automatic t_vol();
    strobe(1, 0, 8'h11);
    check("R3 wiper", wiper_code, 8'h11);
    check("R3 nack", wr_nack, 0);
    check("R3 busy", busy, 0);
    peek("R3 storage untouched", 0, 8'h80);
    stop();
  endtask

  task automatic t_nv_gp();
    strobe(0, 3, 8'h5A);
    check("R4 wiper unchanged for idx3", wiper_code, 8'h11);
    @(negedge clk); ack(); stop();
    check("R5 busy raised", busy, 1);
    count_busy("R5 busy length", PROG);
    peek("R5 storage idx3", 3, 8'h5A);
  endtask

  task automatic t_nv_ivr();
    strobe(0, 0, 8'h3C);
    check("R4 immediate wiper", wiper_code, 8'h3C);
    peek("R4 storage not yet", 0, 8'h80);
    ack(); stop();
    count_busy("R5 busy length idx0", PROG);
    peek("R5 storage idx0", 0, 8'h3C);
  endtask

  task automatic t_discard();
    strobe(0, 2, 8'h77); ack(); bbit(); stop();
    check("R6 bit discard busy", busy, 0);
    strobe(0, 2, 8'h77); stop();
    check("R6 early stop busy", busy, 0);
    strobe(0, 2, 8'h77); ack(); start(); stop();
    check("R6 restart busy", busy, 0);
    peek("R6 storage idx2", 2, 8'h00);
  endtask

  task automatic t_wp();
    wp_n = 0;
    strobe(0, 4, 8'h44);
    check("R7 protected nack", wr_nack, 1);
    strobe(1, 0, 8'h3C);
    check("R3 volatile under protect", wr_nack, 0);
    stop(); wp_n = 1;
    strobe(0, 4, 8'h44); ack();
    wp_n = 0; @(negedge clk); wp_n = 1;
    stop();
    check("R7 pending abort busy", busy, 0);
    peek("R7 pending abort storage", 4, 8'h00);
    strobe(0, 4, 8'h44); ack(); stop();
    wp_n = 0;
    count_busy("R7 cycle completes", PROG);
    wp_n = 1;
    peek("R7 storage idx4", 4, 8'h44);
  endtask

  task automatic t_busy();
    strobe(0, 5, 8'h55); ack(); stop();
    check("R8 not ready", dev_ready, 0);
    strobe(1, 0, 8'h99);
    check("R8 refused", wr_nack, 1);
    check("R8 wiper kept", wiper_code, 8'h3C);
    count_busy("R8 remaining busy", PROG - 1);
    check("R8 ready again", dev_ready, 1);
    peek("R8 storage idx5", 5, 8'h55);
  endtask

  task automatic t_lock();
    strobe(0, 6, 8'h66); ack();
    strobe(0, 6, 8'h67);
    check("R9 second write refused", wr_nack, 1);
    stop();
    check("R9 no program", busy, 0);
    peek("R9 storage idx6", 6, 8'h00);
    strobe(1, 0, 8'h22);
    check("R9 accepted after stop", wr_nack, 0);
    check("R9 wiper", wiper_code, 8'h22);
    stop();
  endtask

  task automatic t_resets();
    rst_n = 0; #1;
    check("R1 wiper in logic reset", wiper_code, 8'h80);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R2 recall after logic reset", wiper_code, 8'h3C);
    peek("R10 survives logic reset", 3, 8'h5A);
    por_n = 0; #1;
    peek("R10 por idx0", 0, 8'h80);
    peek("R10 por idx3", 3, 8'h00);
    check("R1 wiper in por", wiper_code, 8'h80);
    @(negedge clk); por_n = 1;
  endtask

  initial begin
    t_powerup();
    t_vol();
    t_nv_gp();
    t_nv_ivr();
    t_discard();
    t_wp();
    t_busy();
    t_lock();
    t_resets();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule